// File: doc/BRIEF.md
# Low-Power Mode Entry Controller

This block decides when a processor subsystem stops running and how it comes back. Three request pulses can put the core to sleep: wait-for-interrupt, wait-for-event and return-from-handler. A deep-select control bit chooses the target state. With deep-select clear the target is a light sleep, where only the core clock is gated. With deep-select set the target is a stop state, where the peripheral clocks are also gated and the PLL and oscillators are switched off.

Each entry trigger has its own wake rule. A per-line interrupt pending/enable pair and a single wakeup-event input supply the wake conditions. When the event-wait trigger is used with the send-on-pending control set, an interrupt that is pending but disabled also counts as a wake condition.

Leaving stop goes through a settle phase. During that phase the oscillators run again, but the core stays gated for a programmable number of cycles. When flash power-down was selected at entry, a second programmable count is added to that phase.

An event that arrives while the core runs is held in a one-bit latch. A later event-wait request consumes the latch and does not sleep.

Top module: `lpm_ctrl`

## Requirements
- R1: After reset the controller is running: core_run, core_clk_en, periph_clk_en and pll_osc_en are 1, and flash_pd_req is 0.
- R2: While running, a wfi_req pulse with no interrupt both pending and enabled (irq_pend & irq_en all zero) enters a low-power state at the next edge. If such an interrupt exists, the request is ignored and the core keeps running.
- R3: While running, a wfe_req pulse when an event is pending (the latch is set, or wake_evt is high in the same cycle) clears the latch and keeps the core running. Otherwise it enters a low-power state. A wake_evt pulse while running sets the latch when it is not consumed in the same cycle.
- R4: While running, an exc_ret pulse enters a low-power state only when sleep_on_exit is 1 and no enabled interrupt is pending. Otherwise it has no effect.
- R5: A low-power state entered by wfi_req or exc_ret ends only when some interrupt is both pending and enabled. Disabled pending lines and wake_evt do not end it.
- R6: A low-power state entered by wfe_req with sev_on_pend = 0 at entry ends only on wake_evt. Pending interrupts do not end it.
- R7: A low-power state entered by wfe_req with sev_on_pend = 1 at entry ends on wake_evt or on any pending interrupt line, whether enabled or not.
- R8: Light sleep (deep_sel = 0 at entry) gates only core_clk_en. core_run returns at the edge that samples the wake condition.
- R9: With deep_sel = 1 at entry, the stop state drives core_clk_en, periph_clk_en and pll_osc_en to 0.
- R10: flash_pd_req is 1 exactly while in stop, and only when flash_pd_en was 1 at entry.
- R11: A stop wake first passes through a settle phase. In that phase pll_osc_en is 1 and core_clk_en, periph_clk_en and core_run are 0. The phase lasts osc_settle+1 cycles, or osc_settle+flash_extra+1 cycles when flash power-down was captured at entry. Both counts are sampled at the waking edge.
- R12: When several requests arrive together, only the highest one is evaluated, in the order wfi_req, then wfe_req, then exc_ret. core_run and core_clk_en are 1 only in the running state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wfi_req | input | 1 | Wait-for-interrupt request pulse |
| wfe_req | input | 1 | Wait-for-event request pulse |
| exc_ret | input | 1 | Return-from-handler pulse |
| deep_sel | input | 1 | 1 selects stop, 0 selects light sleep |
| sleep_on_exit | input | 1 | Sleep automatically on handler return |
| sev_on_pend | input | 1 | Any pending interrupt counts as an event |
| flash_pd_en | input | 1 | Power the flash down in stop |
| irq_pend | input | NUM_IRQ | Per-line interrupt pending flags |
| irq_en | input | NUM_IRQ | Per-line interrupt enable flags |
| wake_evt | input | 1 | Wakeup event pulse |
| osc_settle | input | CNT_W | Oscillator settle cycles |
| flash_extra | input | CNT_W | Extra cycles for flash restart |
| core_clk_en | output | 1 | Core clock gate enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| pll_osc_en | output | 1 | PLL and oscillator enable |
| flash_pd_req | output | 1 | Flash power-down request |
| core_run | output | 1 | Core is running |

## Verification
The checker watches several properties on every cycle. A blocked wait-for-interrupt must leave the core running, and an allowed one must gate the core clock. A handler return without sleep-on-exit must have no effect. Stop must never be followed directly by running. Light sleep must only be followed by sleep or run, and the flash request is only allowed while the oscillators are off. The wake rules depend on the entry trigger and on settings captured at entry, and the settle length depends on two counts. Only the bench's scenarios show these, by comparing each cycle against its model and by timing the settle phase directly.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_SLEEP = 2'd1,
    ST_STOP  = 2'd2,
    ST_WAKE  = 2'd3
  } lpm_state_e;

  typedef enum logic [1:0] {
    REQ_NONE = 2'd0,
    REQ_WFI  = 2'd1,
    REQ_WFE  = 2'd2,
    REQ_RET  = 2'd3
  } lpm_req_e;
endpackage

// File: rtl/lpm_entry_dec.sv
module lpm_entry_dec
  import lpm_pkg::*;
(
  input  logic     wfi_i,
  input  logic     wfe_i,
  input  logic     ret_i,
  input  logic     sleep_on_exit_i,
  input  logic     irq_act_i,
  input  logic     evt_pend_i,
  output lpm_req_e sel_o,
  output logic     go_o,
  output logic     consume_o
);
  // fixed priority: wfi, then wfe, then handler return
  always_comb begin
    sel_o = REQ_NONE;
    if (wfi_i)      sel_o = REQ_WFI;
    else if (wfe_i) sel_o = REQ_WFE;
    else if (ret_i) sel_o = REQ_RET;
  end

  always_comb begin
    go_o      = 1'b0;
    consume_o = 1'b0;
    unique case (sel_o)
      REQ_WFI: go_o = !irq_act_i;
      REQ_WFE: begin
        go_o      = !evt_pend_i;
        consume_o = evt_pend_i;
      end
      REQ_RET: go_o = sleep_on_exit_i && !irq_act_i;
      default: ;
    endcase
  end
endmodule

// File: rtl/lpm_wake_eval.sv
module lpm_wake_eval #(
  parameter int NUM_IRQ = 8
) (
  input  logic [NUM_IRQ-1:0] irq_pend_i,
  input  logic [NUM_IRQ-1:0] irq_en_i,
  input  logic               wake_evt_i,
  input  logic               kind_wfe_i,
  input  logic               sev_cap_i,
  output logic               irq_act_o,
  output logic               wake_o
);
  logic any_pend;

  assign irq_act_o = |(irq_pend_i & irq_en_i);
  assign any_pend  = |irq_pend_i;

  always_comb begin
    if (kind_wfe_i) wake_o = wake_evt_i || (sev_cap_i && any_pend);
    else            wake_o = irq_act_o;
  end
endmodule

// File: rtl/lpm_settle_cnt.sv
module lpm_settle_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] settle_i,
  input  logic [CNT_W-1:0] extra_i,
  input  logic             add_extra_i,
  input  logic             count_en_i,
  output logic             done_o
);
  localparam int TW = CNT_W + 1;

  logic [TW-1:0] cnt_q;
  logic [TW-1:0] cnt_d;
  logic          cnt_ce;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_ce = 1'b0;
    if (load_i) begin
      cnt_ce = 1'b1;
      cnt_d  = {1'b0, settle_i} + (add_extra_i ? {1'b0, extra_i} : '0);
    end else if (count_en_i && (cnt_q != '0)) begin
      cnt_ce = 1'b1;
      cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
#(
  parameter int NUM_IRQ = 8,
  parameter int CNT_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wfi_req,
  input  logic               wfe_req,
  input  logic               exc_ret,
  input  logic               deep_sel,
  input  logic               sleep_on_exit,
  input  logic               sev_on_pend,
  input  logic               flash_pd_en,
  input  logic [NUM_IRQ-1:0] irq_pend,
  input  logic [NUM_IRQ-1:0] irq_en,
  input  logic               wake_evt,
  input  logic [CNT_W-1:0]   osc_settle,
  input  logic [CNT_W-1:0]   flash_extra,
  output logic               core_clk_en,
  output logic               periph_clk_en,
  output logic               pll_osc_en,
  output logic               flash_pd_req,
  output logic               core_run
);
  lpm_state_e state_q, state_d;
  logic       kind_q, sev_q, fpd_q, latch_q;
  logic       latch_d, latch_ce, cap_ce;
  lpm_req_e   sel;
  logic       go, consume, irq_act, wake, cnt_done, cnt_load;
  logic       in_run;

  assign in_run = (state_q == ST_RUN);

  lpm_wake_eval #(.NUM_IRQ(NUM_IRQ)) wake_i (
    .irq_pend_i (irq_pend),
    .irq_en_i   (irq_en),
    .wake_evt_i (wake_evt),
    .kind_wfe_i (kind_q),
    .sev_cap_i  (sev_q),
    .irq_act_o  (irq_act),
    .wake_o     (wake)
  );

  lpm_entry_dec entry_i (
    .wfi_i           (wfi_req),
    .wfe_i           (wfe_req),
    .ret_i           (exc_ret),
    .sleep_on_exit_i (sleep_on_exit),
    .irq_act_i       (irq_act),
    .evt_pend_i      (latch_q || wake_evt),
    .sel_o           (sel),
    .go_o            (go),
    .consume_o       (consume)
  );

  lpm_settle_cnt #(.CNT_W(CNT_W)) cnt_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (cnt_load),
    .settle_i    (osc_settle),
    .extra_i     (flash_extra),
    .add_extra_i (fpd_q),
    .count_en_i  (state_q == ST_WAKE),
    .done_o      (cnt_done)
  );

  // next state
  always_comb begin
    state_d  = state_q;
    cnt_load = 1'b0;
    cap_ce   = 1'b0;
    unique case (state_q)
      ST_RUN: if (go) begin
        cap_ce  = 1'b1;
        state_d = deep_sel ? ST_STOP : ST_SLEEP;
      end
      ST_SLEEP: if (wake) state_d = ST_RUN;
      ST_STOP: if (wake) begin
        state_d  = ST_WAKE;
        cnt_load = 1'b1;
      end
      ST_WAKE: if (cnt_done) state_d = ST_RUN;
      default: state_d = ST_RUN;
    endcase
  end

  // event latch, updated only while running
  always_comb begin
    latch_ce = in_run && (consume || wake_evt);
    latch_d  = !consume;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_RUN;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= 1'b0;
      sev_q  <= 1'b0;
      fpd_q  <= 1'b0;
    end else if (cap_ce) begin
      kind_q <= (sel == REQ_WFE);
      sev_q  <= sev_on_pend;
      fpd_q  <= flash_pd_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        latch_q <= 1'b0;
    else if (latch_ce) latch_q <= latch_d;
  end

  assign core_run      = in_run;
  assign core_clk_en   = in_run;
  assign periph_clk_en = in_run || (state_q == ST_SLEEP);
  assign pll_osc_en    = (state_q != ST_STOP);
  assign flash_pd_req  = (state_q == ST_STOP) && fpd_q;
endmodule

// File: rtl/lpm_ctrl_chk.sv
module lpm_ctrl_chk #(
  parameter int NUM_IRQ = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wfi_req,
  input logic               wfe_req,
  input logic               exc_ret,
  input logic               deep_sel,
  input logic               sleep_on_exit,
  input logic [NUM_IRQ-1:0] irq_pend,
  input logic [NUM_IRQ-1:0] irq_en,
  input logic               core_clk_en,
  input logic               periph_clk_en,
  input logic               pll_osc_en,
  input logic               flash_pd_req,
  input logic               core_run
);
  logic irq_on;
  logic in_sleep;
  assign irq_on   = |(irq_pend & irq_en);
  assign in_sleep = !core_clk_en && periph_clk_en;

  AST_WFI_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    core_run && wfi_req && irq_on |=> core_run); // R2
  AST_WFI_ENTER: assert property (@(posedge clk) disable iff (!rst_n)
    core_run && wfi_req && !irq_on && !deep_sel |=> !core_clk_en && periph_clk_en); // R2
  AST_RET_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    core_run && exc_ret && !wfi_req && !wfe_req && !sleep_on_exit |=> core_run); // R4
  AST_STOP_ENTER: assert property (@(posedge clk) disable iff (!rst_n)
    core_run && wfi_req && !irq_on && deep_sel |=> !pll_osc_en && !periph_clk_en); // R9
  AST_STOP_NOT_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    !pll_osc_en |=> !core_run); // R11
  AST_FLASH_IN_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    flash_pd_req |-> !pll_osc_en); // R10
  AST_SLEEP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    in_sleep |=> (core_run || in_sleep)); // R8
endmodule

bind lpm_ctrl lpm_ctrl_chk #(.NUM_IRQ(NUM_IRQ)) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .wfi_req       (wfi_req),
  .wfe_req       (wfe_req),
  .exc_ret       (exc_ret),
  .deep_sel      (deep_sel),
  .sleep_on_exit (sleep_on_exit),
  .irq_pend      (irq_pend),
  .irq_en        (irq_en),
  .core_clk_en   (core_clk_en),
  .periph_clk_en (periph_clk_en),
  .pll_osc_en    (pll_osc_en),
  .flash_pd_req  (flash_pd_req),
  .core_run      (core_run)
);

// File: tb/lpm_ctrl_tb_top.sv
module lpm_ctrl_tb_top;
  localparam int NI = 8;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic wfi_req, wfe_req, exc_ret, deep_sel, sleep_on_exit, sev_on_pend, flash_pd_en;
  logic [NI-1:0] irq_pend, irq_en;
  logic wake_evt;
  logic [CW-1:0] osc_settle, flash_extra;
  logic core_clk_en, periph_clk_en, pll_osc_en, flash_pd_req, core_run;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  lpm_ctrl #(.NUM_IRQ(NI), .CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .wfi_req(wfi_req), .wfe_req(wfe_req), .exc_ret(exc_ret),
    .deep_sel(deep_sel), .sleep_on_exit(sleep_on_exit), .sev_on_pend(sev_on_pend),
    .flash_pd_en(flash_pd_en), .irq_pend(irq_pend), .irq_en(irq_en), .wake_evt(wake_evt),
    .osc_settle(osc_settle), .flash_extra(flash_extra), .core_clk_en(core_clk_en),
    .periph_clk_en(periph_clk_en), .pll_osc_en(pll_osc_en), .flash_pd_req(flash_pd_req),
    .core_run(core_run)
  );

  // model state: 0 run, 1 sleep, 2 stop, 3 settle
  int    m_st;
  logic  m_kind, m_sev, m_fpd, m_latch;
  int    m_cnt;
  string m_tag;

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [4:0] exp_outs();
    logic run;
    run = (m_st == 0);
    return {run, run, (m_st <= 1), (m_st != 2), (m_st == 2) && m_fpd};
  endfunction

  task automatic enter(logic k);
    m_st   = deep_sel ? 2 : 1;
    m_kind = k;
    m_sev  = sev_on_pend;
    m_fpd  = flash_pd_en;
  endtask

  task automatic model_step();
    logic act, anyp, evp, wk;
    act  = |(irq_pend & irq_en);
    anyp = |irq_pend;
    case (m_st)
      0: begin
        evp = m_latch || wake_evt;
        if (wfi_req) begin
          m_tag = "R2";
          if (!act) enter(1'b0);
          if (wake_evt) m_latch = 1'b1;
        end else if (wfe_req) begin
          m_tag = "R3";
          if (evp) m_latch = 1'b0;
          else enter(1'b1);
        end else begin
          m_tag = exc_ret ? "R4" : "R12";
          if (exc_ret && sleep_on_exit && !act) enter(1'b0);
          if (wake_evt) m_latch = 1'b1;
        end
      end
      1, 2: begin
        wk = m_kind ? (wake_evt || (m_sev && anyp)) : act;
        m_tag = m_kind ? (m_sev ? "R7" : "R6") : "R5";
        if (m_st == 2 && !wk) m_tag = m_fpd ? "R10" : "R9";
        if (wk) begin
          if (m_st == 1) begin
            m_st = 0; m_tag = "R8";
          end else begin
            m_st = 3; m_tag = "R11";
            m_cnt = int'(osc_settle) + (m_fpd ? int'(flash_extra) : 0);
          end
        end
      end
      default: begin
        m_tag = "R11";
        if (m_cnt == 0) m_st = 0;
        else m_cnt--;
      end
    endcase
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    #2;
    check(m_tag, int'({core_run, core_clk_en, periph_clk_en, pll_osc_en, flash_pd_req}),
          int'(exp_outs()));
    wfi_req = 0; wfe_req = 0; exc_ret = 0; wake_evt = 0;
  endtask

  initial begin
    #(200000 * 10);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    void'($urandom(32'd2024));
    rst_n = 0; wfi_req = 0; wfe_req = 0; exc_ret = 0; deep_sel = 0; sleep_on_exit = 0;
    sev_on_pend = 0; flash_pd_en = 0; irq_pend = '0; irq_en = '0; wake_evt = 0;
    osc_settle = '0; flash_extra = '0;
    m_st = 0; m_kind = 0; m_sev = 0; m_fpd = 0; m_latch = 0; m_cnt = 0; m_tag = "R1";
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    // R1 reset state
    check("R1", int'({core_run, core_clk_en, periph_clk_en, pll_osc_en, flash_pd_req}), 5'b11110);

    // R3: latched event consumed, second wfe sleeps
    wake_evt = 1; tick();
    wfe_req = 1; tick();
    check("R3", int'(core_run), 1);
    wfe_req = 1; tick();
    check("R3", int'(core_run), 0);
    // R6: enabled pending irq ignored
    irq_en = 8'h01; irq_pend = 8'h01; tick(); tick();
    check("R6", int'(core_run), 0);
    wake_evt = 1; tick();
    check("R8", int'(core_run), 1);
    // R2: wfi ignored with enabled pending irq
    wfi_req = 1; tick();
    check("R2", int'(core_run), 1);
    irq_pend = '0;
    // R7: sev sleep woken by disabled irq
    sev_on_pend = 1; wfe_req = 1; tick();
    check("R7", int'(core_run), 0);
    irq_en = '0; irq_pend = 8'h10; tick();
    check("R7", int'(core_run), 1);
    irq_pend = '0; sev_on_pend = 0;
    // R12: wfi wins over wfe when both pulse (latch clear, so wfi sleeps as kind irq)
    wfi_req = 1; wfe_req = 1; tick();
    wake_evt = 1; tick();
    check("R12", int'(core_run), 0);
    irq_en = 8'h02; irq_pend = 8'h02; tick();
    check("R12", int'(core_run), 1);
    irq_pend = '0;
    // R10/R11: stop with flash power-down, settle 3 + extra 2
    deep_sel = 1; flash_pd_en = 1; wfi_req = 1; tick();
    check("R10", int'(flash_pd_req), 1);
    check("R9", int'(pll_osc_en), 0);
    tick();
    osc_settle = 8'd3; flash_extra = 8'd2; irq_pend = 8'h02; tick();
    irq_pend = '0;
    n = 0;
    while (!core_run && n < 50) begin n++; tick(); end
    check("R11", n, 6);
    // R11 without flash power-down
    flash_pd_en = 0; wfi_req = 1; tick();
    check("R10", int'(flash_pd_req), 0);
    osc_settle = 8'd1; irq_pend = 8'h02; tick();
    irq_pend = '0;
    n = 0;
    while (!core_run && n < 50) begin n++; tick(); end
    check("R11", n, 2);
    deep_sel = 0;

    // random phase
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom % 100;
      wfi_req = (r < 5);
      wfe_req = (r >= 5 && r < 10) || (r == 99);
      exc_ret = (r >= 10 && r < 15) || (r == 98);
      wake_evt = ($urandom % 25) == 0;
      deep_sel = ($urandom % 3) == 0;
      sleep_on_exit = $urandom % 2;
      sev_on_pend = $urandom % 2;
      flash_pd_en = $urandom % 2;
      irq_pend = (($urandom % 10) == 0) ? (8'h01 << ($urandom % 8)) : 8'h00;
      if (i % 64 == 0) irq_en = 8'($urandom);
      osc_settle = 8'($urandom % 8);
      flash_extra = 8'($urandom % 8);
      tick();
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule